// File: doc/BRIEF.md
# Byte-Lane Static RAM Emulator

This block is a clocked, synthesizable stand-in for a 16-bit asynchronous static RAM with two byte lanes. A testbench or an FPGA prototype uses it as the memory target. It accepts four active-low controls: a select, a write strobe, an output enable and one lane enable per byte. It also takes an address, whose width is a parameter, and write data. Storage is a register array with one slice per lane, so a write can mask out either byte.

A real device floats its pins. This model instead returns read data with one drive flag per lane. A lane whose flag is low shows zero on its data bits. A two-bit mode output reports the cycle's operation: deselect/standby, read, write or output-disabled. The controller keeps that mode as a registered state.

The states are DESEL, READ, WRITE and OUTDIS. At every clock edge the state moves to the state that the sampled controls decode to, and any state can be reached from any other.
- GO_DESEL is taken when the select is high.
- GO_WRITE is taken when the select and the write strobe are both low.
- GO_READ is taken when the select is low, the write strobe is high, the output enable is low and at least one lane enable is low.
- GO_OUTDIS is taken in every other case where the select is low.

Top module: `bl_sram`

## Requirements
- R1: After reset, and while reset is held, mode is 2'b00, rdrive is 2'b00 and rdata is all zeros.
- R2: When sel_n is high at a clock edge, in the next cycle mode is 2'b00 (deselect) and both lanes are undriven, whatever the other inputs are. Nothing is written.
- R3: When sel_n and wen_n are both low at a clock edge, each lane whose lane_n bit is low takes wdata at that edge. In the next cycle mode is 2'b10 (write) and both lanes are undriven. oen_n has no effect on this.
- R4: When sel_n is low, wen_n is high and oen_n is low at a clock edge, and at least one lane_n bit is low, then in the next cycle mode is 2'b01 (read). Each lane whose lane_n bit was low drives the stored byte at the sampled address, and the other lane is undriven.
- R5: When sel_n is low and wen_n is high at a clock edge, and either oen_n is high or lane_n is 2'b11, then in the next cycle mode is 2'b11 (output disabled) and both lanes are undriven.
- R6: lane_n[0] and rdrive[0] belong to data bits 7..0. lane_n[1] and rdrive[1] belong to bits 15..8. Whenever a lane's rdrive bit is low, its rdata bits read zero.
- R7: A read in the cycle right after a write to the same address returns the newly written bytes. A byte excluded from a write keeps its earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the state and outputs |
| sel_n | input | 1 | Active-low chip select |
| wen_n | input | 1 | Active-low write strobe |
| oen_n | input | 1 | Active-low output enable |
| lane_n | input | 2 | Active-low byte-lane enables, bit 0 for the low byte |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero on undriven lanes |
| rdrive | output | 2 | Per-lane drive flag, standing in for the low-impedance state |
| mode | output | 2 | 00 deselect, 01 read, 10 write, 11 output disabled |

## Verification
The bound assertions check on every cycle that the state and the drive flags follow the decode of the controls sampled one edge earlier. These checks cover deselect, write, read and output-disabled, including write taking priority over the output enable. They also check that an undriven lane reads zero. Only the bench's scenarios can show that data values are right. That covers the byte-masked writes into the array, reads returning the bytes at the addressed word, and a read right after a write seeing the new bytes while masked bytes keep their old contents.

// File: rtl/bl_sram_pkg.sv
package bl_sram_pkg;
    typedef enum logic [1:0] {
        DESEL  = 2'b00,
        READ   = 2'b01,
        WRITE  = 2'b10,
        OUTDIS = 2'b11
    } mode_t;
endpackage

// File: rtl/bl_decode.sv
module bl_decode
    import bl_sram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             sel_n,
    input  logic             wen_n,
    input  logic             oen_n,
    input  logic [LANES-1:0] lane_n,
    output mode_t            mode_nx,
    output logic [LANES-1:0] wr_lane,
    output logic [LANES-1:0] rd_lane
);
    always_comb begin
        mode_nx = DESEL;
        wr_lane = '0;
        rd_lane = '0;
        if (!sel_n) begin
            if (!wen_n) begin
                mode_nx = WRITE;
                wr_lane = ~lane_n;
            end else if (!oen_n && (lane_n != {LANES{1'b1}})) begin
                mode_nx = READ;
                rd_lane = ~lane_n;
            end else begin
                mode_nx = OUTDIS;
            end
        end
    end
endmodule

// File: rtl/bl_lane_store.sv
module bl_lane_store #(
    parameter int ADDR_W = 4,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wbyte,
    output logic [LANE_W-1:0] rbyte
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wbyte;
        end
        rbyte <= mem[addr];
    end
endmodule

// File: rtl/bl_sram.sv
module bl_sram
    import bl_sram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wen_n,
    input  logic              oen_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [LANES-1:0]  rdrive,
    output logic [1:0]        mode
);
    mode_t            mode_nx, mode_q;
    logic [LANES-1:0] wr_lane, rd_lane, rd_q;
    logic [DATA_W-1:0] lane_q;

    bl_decode #(.LANES(LANES)) u_dec (
        .sel_n   (sel_n),
        .wen_n   (wen_n),
        .oen_n   (oen_n),
        .lane_n  (lane_n),
        .mode_nx (mode_nx),
        .wr_lane (wr_lane),
        .rd_lane (rd_lane)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        bl_lane_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_store (
            .clk   (clk),
            .wr_en (wr_lane[l]),
            .addr  (addr),
            .wbyte (wdata[l*LANE_W +: LANE_W]),
            .rbyte (lane_q[l*LANE_W +: LANE_W])
        );
        assign rdata[l*LANE_W +: LANE_W] = rdrive[l] ? lane_q[l*LANE_W +: LANE_W] : '0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= DESEL;
            rd_q   <= '0;
        end else begin
            mode_q <= mode_nx;
            rd_q   <= rd_lane;
        end
    end

    // outputs from state
    always_comb begin
        mode = mode_q;
        unique case (mode_q)
            READ:   rdrive = rd_q;
            DESEL:  rdrive = '0;
            WRITE:  rdrive = '0;
            OUTDIS: rdrive = '0;
        endcase
    end
endmodule

// File: rtl/bl_sram_chk.sv
module bl_sram_chk #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sel_n,
    input logic                    wen_n,
    input logic                    oen_n,
    input logic [LANES-1:0]        lane_n,
    input logic [LANES*LANE_W-1:0] rdata,
    input logic [LANES-1:0]        rdrive,
    input logic [1:0]              mode
);
    p_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (mode == 2'b00 && rdrive == '0));

    p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !wen_n) |=> (mode == 2'b10 && rdrive == '0));

    p_read_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && wen_n && !oen_n && lane_n != {LANES{1'b1}})
        |=> (mode == 2'b01 && rdrive == ~$past(lane_n)));

    p_outdis_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && wen_n && (oen_n || lane_n == {LANES{1'b1}}))
        |=> (mode == 2'b11 && rdrive == '0));

    for (genvar l = 0; l < LANES; l++) begin : g_zero
        p_undriven_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !rdrive[l] |-> (rdata[l*LANE_W +: LANE_W] == '0));
    end
endmodule

bind bl_sram bl_sram_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_n  (sel_n),
    .wen_n  (wen_n),
    .oen_n  (oen_n),
    .lane_n (lane_n),
    .rdata  (rdata),
    .rdrive (rdrive),
    .mode   (mode)
);

// File: tb/bl_sram_tb.sv
module bl_sram_tb;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1, wen_n = 1'b1, oen_n = 1'b1;
    logic [1:0]    lane_n = 2'b11;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic [1:0]    rdrive;
    logic [1:0]    mode;

    int total = 0;
    int bad = 0;
    logic [15:0] model [DEPTH];

    always #5 clk = ~clk;

    bl_sram #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wen_n(wen_n), .oen_n(oen_n),
        .lane_n(lane_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdrive(rdrive), .mode(mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, let one rising edge sample, check at the next falling edge
    task automatic op(input string req, input logic s, input logic w, input logic o,
                      input logic [1:0] b, input logic [AW-1:0] a, input logic [15:0] d);
        logic [1:0]  emode, edrv;
        logic [15:0] edata;
        sel_n = s; wen_n = w; oen_n = o; lane_n = b; addr = a; wdata = d;
        @(posedge clk);
        edrv = 2'b00;
        if (s) emode = 2'b00;
        else if (!w) begin
            emode = 2'b10;
            if (!b[0]) model[a][7:0]  = d[7:0];
            if (!b[1]) model[a][15:8] = d[15:8];
        end else if (o || b == 2'b11) emode = 2'b11;
        else begin
            emode = 2'b01;
            edrv = ~b;
        end
        edata = model[a] & {{8{edrv[1]}}, {8{edrv[0]}}};
        @(negedge clk);
        chk(req, {30'd0, mode}, {30'd0, emode});
        chk(req, {30'd0, rdrive}, {30'd0, edrv});
        chk(req, {16'd0, rdata}, {16'd0, edata});
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state while reset is held
        chk("R1", {30'd0, mode}, 32'd0);
        chk("R1", {30'd0, rdrive}, 32'd0);
        chk("R1", {16'd0, rdata}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {30'd0, mode}, 32'd0);

        // R3 full-word fill, oen_n alternated to show it is ignored
        for (int a = 0; a < DEPTH; a++)
            op("R3", 1'b0, 1'b0, a[0], 2'b00, AW'(a), 16'(a * 16'h1357 ^ 16'hA5C3));
        // R4 R5 R6 sweep of every read-side combination at every address
        for (int a = 0; a < DEPTH; a++)
            for (int c = 0; c < 8; c++)
                op("R4", 1'b0, 1'b1, c[2], c[1:0], AW'(a), 16'hFFFF);
        // R2 deselect with every other control combination: nothing written
        for (int c = 0; c < 16; c++)
            op("R2", 1'b1, c[0], c[1], c[3:2], AW'(c), 16'h0F0F ^ 16'(c));
        for (int a = 0; a < DEPTH; a++)
            op("R2", 1'b0, 1'b1, 1'b0, 2'b00, AW'(a), 16'h0);
        // R7 masked writes followed at once by a read of the same address
        for (int a = 0; a < DEPTH; a++)
            for (int b = 0; b < 4; b++) begin
                op("R7", 1'b0, 1'b0, 1'b0, 2'(b), AW'(a), 16'(a * 16'h0B1D + b * 16'h3C01));
                op("R7", 1'b0, 1'b1, 1'b0, 2'b00, AW'(a), 16'h0);
            end
        // R6 lane mapping: single-lane writes with distinct bytes, single-lane reads
        op("R6", 1'b0, 1'b0, 1'b1, 2'b10, AW'(3), 16'hEE11);
        op("R6", 1'b0, 1'b1, 1'b0, 2'b10, AW'(3), 16'h0);
        op("R6", 1'b0, 1'b0, 1'b1, 2'b01, AW'(3), 16'h22DD);
        op("R6", 1'b0, 1'b1, 1'b0, 2'b01, AW'(3), 16'h0);
        op("R6", 1'b0, 1'b1, 1'b0, 2'b00, AW'(3), 16'h0);
        // R5 write-strobe high with all lanes off, then output enable off
        op("R5", 1'b0, 1'b1, 1'b0, 2'b11, AW'(5), 16'h0);
        op("R5", 1'b0, 1'b1, 1'b1, 2'b00, AW'(5), 16'h0);
        op("R2", 1'b1, 1'b1, 1'b1, 2'b11, AW'(0), 16'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule